// File: doc/BRIEF.md
# Short I/O slave address decoder

This block sits behind the bus receivers of a slave I/O module that lives in a 16-bit short I/O address space. On every cycle it compares the upper six address bits against six configuration switches and checks the address modifier against the module's privilege setting. When both match and a data strobe is present, it treats the access as a hit on the module's 1K-byte interface block. It then produces register selects and one-cycle read/write strobes for the function logic, and returns the read data with a data acknowledge.

Only odd byte offsets inside the block hold registers, so every register sits on the low data lane. A built-in identification area returns a manufacturer code, a model code and a revision code. The status byte is supplied by the function logic. Every other location reads as all ones but is still acknowledged, so a probe of an empty offset never hangs the bus. Control pins are plain levels, and no data interface here needs valid/ready flow control: the acknowledge is the only handshake, and its timing follows the bus strobes.

Top module: `sio_addr_decoder`

## Requirements
- R1: An access is decoded only when `addr_strobe` is high, at least one of `ds_lo`/`ds_hi` is high, and `addr[15:10]` equals `base_sw`; without all three there is no strobe, no select and no `dtack`.
- R2: Modifier code 6'h2D (short supervisory) is always accepted; 6'h29 (short non-privileged) is accepted only while `sup_only` is 0; any other code is ignored.
- R3: `dtack` rises one clock after the first decoded cycle, stays high while the access stays decoded, and falls one clock after the strobes are released; accesses are separated by at least one idle cycle.
- R4: A read with `ds_lo` high at byte offset 01h returns the manufacturer code, 03h the model code high byte, 05h the model code low byte, 07h the revision code, and 09h to 3Fh return 00h, all on `rdata[7:0]`.
- R5: A decoded access at byte offset 81h raises `sel_status`, and a read there returns `stat_rdata` on `rdata[7:0]`.
- R6: A decoded access at byte offset 83h raises `sel_vector`; a write there gives a `wr_stb` pulse, and a read there returns FFh on `rdata[7:0]`.
- R7: The high data lane `rdata[15:8]` always reads FFh; a read with `ds_lo` low, or at any odd offset that holds no register, returns FFFFh and is still acknowledged.
- R8: Each decoded access gives exactly one single-cycle pulse, on `rd_stb` for a read (`write` low) or `wr_stb` for a write, in its first decoded cycle.
- R9: After reset `dtack` is 0 and `rdata` is 0000h; `rdata` is also 0000h whenever no read is being acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 15 | Bus address bits 15 to 1 |
| am | input | 6 | Address modifier code |
| addr_strobe | input | 1 | Address strobe, active high |
| ds_lo | input | 1 | Strobe for the odd-byte lane D7..D0 |
| ds_hi | input | 1 | Strobe for the even-byte lane D15..D8 |
| write | input | 1 | 1 for a write access, 0 for a read |
| base_sw | input | 6 | Base address switches, compared with addr[15:10] |
| sup_only | input | 1 | 1: answer supervisory codes only |
| stat_rdata | input | 8 | Status byte from the function logic |
| sel_status | output | 1 | Status register selected |
| sel_vector | output | 1 | Vector register selected |
| rd_stb | output | 1 | One-cycle read strobe |
| wr_stb | output | 1 | One-cycle write strobe |
| dtack | output | 1 | Data acknowledge |
| rdata | output | 16 | Read data, valid while dtack is high |

## Verification
The bench checks the privilege filter from both switch positions. A design that ignored `sup_only` would acknowledge non-privileged code 29h when it should stay silent, and one that rejected 29h outright would leave user programs without access. It reads even-lane-only accesses and empty odd offsets such as 41h to show that these still get an acknowledge with all-ones data; a decoder that left them unacknowledged would hang the bus. It also holds strobes for several cycles, to catch a design that pulses `rd_stb` repeatedly, lets `rdata` drift mid-access, or holds `dtack` past release.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
  localparam logic [5:0] AM_SHORT_SUP = 6'h2D;
  localparam logic [5:0] AM_SHORT_USR = 6'h29;
  localparam logic [9:0] OFF_STATUS   = 10'h081;
  localparam logic [9:0] OFF_VECTOR   = 10'h083;
  localparam logic [7:0] FILL_BYTE    = 8'hFF;

  // identification byte for word index k inside the id area
  function automatic logic [7:0] id_byte(input int k, input logic [7:0] mfr,
                                         input logic [15:0] model, input logic [7:0] rev);
    case (k)
      0:       id_byte = mfr;
      1:       id_byte = model[15:8];
      2:       id_byte = model[7:0];
      3:       id_byte = rev;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sio_match.sv
module sio_match #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 10,
  localparam int BASE_W = ADDR_W - BLK_W
) (
  input  logic [ADDR_W-1:1] addr,
  input  logic [BASE_W-1:0] base_sw,
  input  logic [5:0]        am,
  input  logic              sup_only,
  input  logic              addr_strobe,
  input  logic              ds_lo,
  input  logic              ds_hi,
  output logic              hit
);
  import sio_dec_pkg::*;
  logic base_eq, am_ok, strobed;

  always_comb begin
    base_eq = (addr[ADDR_W-1:BLK_W] == base_sw);
    am_ok   = (am == AM_SHORT_SUP) || ((am == AM_SHORT_USR) && !sup_only);
    strobed = addr_strobe && (ds_lo || ds_hi);
    hit     = base_eq && am_ok && strobed;
  end
endmodule

// File: rtl/sio_id_rom.sv
module sio_id_rom #(
  parameter int          IDX_W = 5,
  parameter logic [7:0]  MFR   = 8'h5A,
  parameter logic [15:0] MODEL = 16'h4C31,
  parameter logic [7:0]  REV   = 8'h03,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       id_data
);
  import sio_dec_pkg::*;
  logic [7:0] table_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign table_q[k] = id_byte(k, MFR, MODEL, REV);
  end

  assign id_data = table_q[idx];
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux #(
  parameter int BLK_W = 10,
  parameter int IDX_W = 5
) (
  input  logic [BLK_W-1:1] word_off,
  input  logic             ds_lo,
  input  logic [7:0]       stat_rdata,
  input  logic [7:0]       id_data,
  output logic             at_status,
  output logic             at_vector,
  output logic [15:0]      rd_val
);
  import sio_dec_pkg::*;
  logic [BLK_W-1:0] byte_off;
  logic             in_id;
  logic [7:0]       lo_byte;

  always_comb begin
    byte_off  = {word_off, 1'b1};
    in_id     = (word_off[BLK_W-1:IDX_W+1] == '0);
    at_status = (byte_off == OFF_STATUS[BLK_W-1:0]);
    at_vector = (byte_off == OFF_VECTOR[BLK_W-1:0]);
    if (in_id)          lo_byte = id_data;
    else if (at_status) lo_byte = stat_rdata;
    else                lo_byte = FILL_BYTE;
    rd_val = {FILL_BYTE, ds_lo ? lo_byte : FILL_BYTE};
  end
endmodule

// File: rtl/sio_ack_ctrl.sv
module sio_ack_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          write,
  input  logic [DW-1:0] rd_val,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          dtack,
  output logic [DW-1:0] rdata
);
  logic first;

  assign first  = hit && !dtack;
  assign rd_stb = first && !write;
  assign wr_stb = first && write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dtack <= 1'b0;
      rdata <= '0;
    end else begin
      dtack <= hit;
      if (hit && !write) begin
        if (first) rdata <= rd_val;
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/sio_addr_decoder.sv
module sio_addr_decoder #(
  parameter int          ADDR_W = 16,
  parameter int          BLK_W  = 10,
  parameter logic [7:0]  MFR    = 8'h5A,
  parameter logic [15:0] MODEL  = 16'h4C31,
  parameter logic [7:0]  REV    = 8'h03,
  localparam int BASE_W = ADDR_W - BLK_W,
  localparam int IDX_W  = 5,
  localparam int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr,
  input  logic [5:0]        am,
  input  logic              addr_strobe,
  input  logic              ds_lo,
  input  logic              ds_hi,
  input  logic              write,
  input  logic [BASE_W-1:0] base_sw,
  input  logic              sup_only,
  input  logic [7:0]        stat_rdata,
  output logic              sel_status,
  output logic              sel_vector,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              dtack,
  output logic [DW-1:0]     rdata
);
  logic          hit, at_status, at_vector;
  logic [7:0]    id_data;
  logic [DW-1:0] rd_val;

  sio_match #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_match (
    .addr(addr), .base_sw(base_sw), .am(am), .sup_only(sup_only),
    .addr_strobe(addr_strobe), .ds_lo(ds_lo), .ds_hi(ds_hi), .hit(hit));

  sio_id_rom #(.IDX_W(IDX_W), .MFR(MFR), .MODEL(MODEL), .REV(REV)) u_rom (
    .idx(addr[IDX_W:1]), .id_data(id_data));

  sio_rd_mux #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_mux (
    .word_off(addr[BLK_W-1:1]), .ds_lo(ds_lo), .stat_rdata(stat_rdata),
    .id_data(id_data), .at_status(at_status), .at_vector(at_vector),
    .rd_val(rd_val));

  sio_ack_ctrl #(.DW(DW)) u_ack (
    .clk(clk), .rst_n(rst_n), .hit(hit), .write(write), .rd_val(rd_val),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .dtack(dtack), .rdata(rdata));

  assign sel_status = hit && at_status;
  assign sel_vector = hit && at_vector;
endmodule

module sio_addr_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:1]       addr,
  input logic [5:0]              am,
  input logic                    addr_strobe,
  input logic                    ds_lo,
  input logic                    ds_hi,
  input logic                    write,
  input logic [ADDR_W-BLK_W-1:0] base_sw,
  input logic                    sup_only,
  input logic                    sel_status,
  input logic                    sel_vector,
  input logic                    rd_stb,
  input logic                    wr_stb,
  input logic                    dtack,
  input logic [15:0]             rdata
);
  a_r1_base_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (addr[ADDR_W-1:BLK_W] == base_sw) && addr_strobe && (ds_lo || ds_hi));
  a_r2_modifier: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (am == 6'h2D) || (am == 6'h29 && !sup_only));
  a_r3_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |=> dtack);
  a_r3_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_strobe |=> !dtack);
  a_r5_sel_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_status || sel_vector) |-> addr_strobe && $onehot0({sel_status, sel_vector}));
  a_r7_high_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != 16'h0000) |-> (rdata[15:8] == 8'hFF) && dtack);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |=> !(rd_stb || wr_stb));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack && $past(dtack) && addr_strobe) |-> $stable(rdata));
endmodule

bind sio_addr_decoder sio_addr_decoder_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (.*);

// File: tb/sio_addr_decoder_tb.sv
module sio_addr_decoder_tb_top;
  localparam logic [5:0] BASE = 6'h2B;
  localparam logic [5:0] SUP = 6'h2D, USR = 6'h29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:1] addr = '0;
  logic [5:0] am = '0, base_sw = BASE;
  logic addr_strobe = 0, ds_lo = 0, ds_hi = 0, write = 0, sup_only = 0;
  logic [7:0] stat_rdata = 8'hC6;
  logic sel_status, sel_vector, rd_stb, wr_stb, dtack;
  logic [15:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_addr_decoder dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full access; checks strobe pulse, ack timing, data hold and release
  task automatic access(input string req, input logic [5:0] base, input logic [9:0] off,
                        input logic [5:0] code, input logic lo, input logic hi,
                        input logic wr, input logic exp_ack, input logic [15:0] exp_rd);
    @(negedge clk);
    addr = {base, off[9:1]}; am = code; ds_lo = lo; ds_hi = hi; write = wr; addr_strobe = 1;
    #1;
    chk({req, " R8 rd_stb"}, rd_stb, exp_ack && !wr);
    chk({req, " R8 wr_stb"}, wr_stb, exp_ack && wr);
    @(negedge clk);
    chk({req, " R3 dtack rise"}, dtack, exp_ack);
    if (exp_ack && !wr) chk({req, " data"}, rdata, exp_rd);
    chk({req, " R8 no second pulse"}, rd_stb | wr_stb, 1'b0);
    @(negedge clk);
    chk({req, " R3 dtack hold"}, dtack, exp_ack);
    if (exp_ack && !wr) chk({req, " R3 data hold"}, rdata, exp_rd);
    addr_strobe = 0; ds_lo = 0; ds_hi = 0; write = 0;
    @(negedge clk);
    chk({req, " R3 dtack release"}, dtack, 1'b0);
    chk({req, " R9 idle data"}, rdata, 16'h0000);
  endtask

  task automatic t_reset();
    chk("R9 reset dtack", dtack, 1'b0);
    chk("R9 reset rdata", rdata, 16'h0000);
  endtask

  task automatic t_id();
    access("R4 mfr 01h", BASE, 10'h001, SUP, 1, 0, 0, 1, 16'hFF5A);
    access("R4 model hi 03h", BASE, 10'h003, SUP, 1, 0, 0, 1, 16'hFF4C);
    access("R4 model lo 05h", BASE, 10'h005, SUP, 1, 0, 0, 1, 16'hFF31);
    access("R4 rev 07h", BASE, 10'h007, SUP, 1, 0, 0, 1, 16'hFF03);
    access("R4 blank 09h", BASE, 10'h009, SUP, 1, 0, 0, 1, 16'hFF00);
    access("R4 blank 3Fh", BASE, 10'h03F, SUP, 1, 0, 0, 1, 16'hFF00);
    access("R7 word read 05h", BASE, 10'h005, SUP, 1, 1, 0, 1, 16'hFF31);
  endtask

  task automatic t_status();
    @(negedge clk);
    addr = {BASE, 9'h040}; am = SUP; ds_lo = 1; addr_strobe = 1; write = 0;
    #1;
    chk("R5 sel_status", sel_status, 1'b1);
    chk("R5 sel_vector low", sel_vector, 1'b0);
    addr_strobe = 0; ds_lo = 0;
    @(negedge clk);
    access("R5 status read", BASE, 10'h081, SUP, 1, 0, 0, 1, {8'hFF, stat_rdata});
    stat_rdata = 8'h3B;
    access("R5 status read 2", BASE, 10'h081, SUP, 1, 0, 0, 1, 16'hFF3B);
  endtask

  task automatic t_vector();
    @(negedge clk);
    addr = {BASE, 9'h041}; am = SUP; ds_lo = 1; addr_strobe = 1; write = 1;
    #1;
    chk("R6 sel_vector", sel_vector, 1'b1);
    chk("R6 wr_stb", wr_stb, 1'b1);
    addr_strobe = 0; ds_lo = 0; write = 0;
    @(negedge clk);
    @(negedge clk);
    access("R6 vector write", BASE, 10'h083, SUP, 1, 0, 1, 1, 16'h0000);
    access("R6 vector read", BASE, 10'h083, SUP, 1, 0, 0, 1, 16'hFFFF);
  endtask

  task automatic t_unpop();
    access("R7 empty 41h", BASE, 10'h041, SUP, 1, 0, 0, 1, 16'hFFFF);
    access("R7 empty 3FFh", BASE, 10'h3FF, SUP, 1, 0, 0, 1, 16'hFFFF);
    access("R7 even lane only", BASE, 10'h001, SUP, 0, 1, 0, 1, 16'hFFFF);
  endtask

  task automatic t_base();
    access("R1 base miss", BASE ^ 6'h01, 10'h001, SUP, 1, 0, 0, 0, 16'h0000);
    access("R1 base miss high", BASE ^ 6'h20, 10'h081, SUP, 1, 0, 0, 0, 16'h0000);
    access("R1 no data strobe", BASE, 10'h001, SUP, 0, 0, 0, 0, 16'h0000);
    base_sw = 6'h00;
    access("R1 base 00", 6'h00, 10'h007, SUP, 1, 0, 0, 1, 16'hFF03);
    base_sw = BASE;
  endtask

  task automatic t_am();
    sup_only = 1;
    access("R2 user code blocked", BASE, 10'h001, USR, 1, 0, 0, 0, 16'h0000);
    access("R2 sup code sup_only", BASE, 10'h001, SUP, 1, 0, 0, 1, 16'hFF5A);
    sup_only = 0;
    access("R2 user code allowed", BASE, 10'h003, USR, 1, 0, 0, 1, 16'hFF4C);
    access("R2 other code", BASE, 10'h001, 6'h3D, 1, 0, 0, 0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_id();
    t_status();
    t_vector();
    t_unpop();
    t_base();
    t_am();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule